// File: doc/BRIEF.md
# Serial Error-Trapping Decoder for Cyclic Hamming Codes

This block decodes a stream of hard-decision codewords of a cyclic single-error-correcting Hamming code, one bit per beat. While a word arrives, a shift-register divider reduces it modulo the generator polynomial to form its syndrome. The finished word and its syndrome then pass to an output stage. That stage sends the bits out in arrival order and multiplies the syndrome by x once per beat. When the rotated syndrome matches the pattern of an error in the bit now leaving, that bit is inverted and flagged. No lookup table is involved. The pattern is the constant x^(N-1) mod g(x), computed when the design is elaborated.

The block is meant for the outer stage of an iterative product-code decoder. Each output beat carries a correction flag, which shows the inner decoder which bit positions were changed. Each word carries a status flag that is 1 when the received syndrome was zero. A word already known to be good can be marked at its first beat so that it passes through untouched. The code length N, the parity width R and the generator polynomial are parameters.

Top module: `cyc_ham_trap_dec`

## Requirements
- R1: A word whose syndrome is zero comes out bit-for-bit unchanged, with `out_fix` low on every beat and `out_ok` high on every beat.
- R2: A word with exactly one flipped bit, at any of the N positions, comes out as the original codeword. `out_fix` is high only on the beat of the flipped bit, and `out_ok` is low.
- R3: At most one bit per word is inverted. `out_fix` is high exactly on the beats where `out_data` differs from the received bit, and never in a word with `out_ok` high.
- R4: If `in_bypass` is high on the first beat of a word, the word passes unchanged with `out_fix` low and `out_ok` high, even when its syndrome is nonzero.
- R5: `in_bypass` is ignored on every beat other than the first beat of a word.
- R6: A beat accepted with `in_sop` high starts a new word. Bits of an unfinished earlier word are dropped and never emitted. A word also starts at the first beat after reset and after each completed word.
- R7: Beat 0 of a word is the coefficient of x^(N-1) and beat N-1 is the coefficient of x^0. Bits leave in arrival order, with `out_sop` on beat 0 and `out_eop` on beat N-1. `GEN` holds the coefficients of x^0..x^(R-1) of g(x); the x^R term is implied.
- R8: While `out_valid` is high and `out_ready` is low, all output fields hold their values.
- R9: When the output stage is idle, the first beat of a word becomes valid at the second rising edge after its last bit is accepted. While `out_ready` stays high, `in_ready` never drops, so words stream back to back.
- R10: After reset `out_valid` is low and `in_ready` is high.
- R11: `out_ok` is constant across all beats of a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Input beat can be taken |
| in_data | input | 1 | Received hard-decision bit |
| in_sop | input | 1 | First bit of a new word |
| in_bypass | input | 1 | On the first beat: treat the word as already good |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream takes the output beat |
| out_data | output | 1 | Decoded bit |
| out_fix | output | 1 | This bit was inverted |
| out_ok | output | 1 | Word syndrome was zero (or bypassed) |
| out_sop | output | 1 | First beat of an output word |
| out_eop | output | 1 | Last beat of an output word |

## Verification
A corrupted syndrome register either misses the trap or fires it at the wrong beat. The error then shows in the same word: a wrong bit together with a misplaced `out_fix`, no later than beat N-1. A wrong beat counter shifts `out_sop`/`out_eop` or splits words. The next handoff then drops or merges a whole word, which appears as missing or extra output beats. Errors are injected at every position, under random backpressure and input gaps, so a trap placed one beat early or late is caught.

// File: rtl/ctd_pkg.sv
package ctd_pkg;
    localparam int SYN_W_MAX = 16;
    typedef logic [SYN_W_MAX-1:0] syn_t;

    // multiply a residue by x modulo g(x); gen holds g without its top term
    function automatic syn_t syn_mulx(input syn_t s, input syn_t gen, input int r);
        syn_t t;
        logic top;
        top = s[r-1];
        t = (s << 1) & ((syn_t'(1) << r) - syn_t'(1));
        if (top) t = t ^ gen;
        return t;
    endfunction

    // Horner step: s*x + b modulo g(x)
    function automatic syn_t syn_step(input syn_t s, input logic b, input syn_t gen, input int r);
        syn_t t;
        t = syn_mulx(s, gen, r);
        t[0] = t[0] ^ b;
        return t;
    endfunction

    // residue of x^(n-1): syndrome of an error in the first bit sent
    function automatic syn_t syn_trap(input int n, input syn_t gen, input int r);
        syn_t t;
        t = syn_t'(1);
        for (int i = 0; i < n - 1; i++) t = syn_mulx(t, gen, r);
        return t;
    endfunction
endpackage

// File: rtl/ctd_collect.sv
module ctd_collect
    import ctd_pkg::*;
#(
    parameter int N = 127,
    parameter int R = 7,
    parameter logic [R-1:0] GEN = 7'h09
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_valid,
    input  logic         bit_data,
    input  logic         bit_sop,
    input  logic         bit_bypass,
    input  logic         take,
    output logic         rdy,
    output logic         full,
    output logic [N-1:0] word,
    output logic [R-1:0] syn,
    output logic         byp
);
    localparam int CW = $clog2(N + 1);

    typedef struct packed {
        logic [N-1:0]  word;
        logic [R-1:0]  syn;
        logic [CW-1:0] cnt;
        logic          full;
        logic          byp;
    } col_t;

    col_t st_q, st_d;

    assign rdy  = !st_q.full || take;
    assign full = st_q.full;
    assign word = st_q.word;
    assign syn  = st_q.syn;
    assign byp  = st_q.byp;

    always_comb begin
        logic         fresh;
        syn_t         nxt;
        logic [CW:0]  cnt_n;
        st_d  = st_q;
        fresh = 1'b0;
        nxt   = '0;
        cnt_n = '0;
        if (take) st_d.full = 1'b0;
        if (bit_valid && rdy) begin
            fresh      = bit_sop || (st_q.cnt == '0);
            nxt        = syn_step(fresh ? syn_t'(0) : syn_t'(st_q.syn), bit_data, syn_t'(GEN), R);
            st_d.syn   = nxt[R-1:0];
            st_d.word  = {st_q.word[N-2:0], bit_data};
            if (fresh) begin
                st_d.byp = bit_bypass;
                cnt_n    = (CW+1)'(1);
            end else begin
                cnt_n    = {1'b0, st_q.cnt} + (CW+1)'(1);
            end
            if (cnt_n == (CW+1)'(N)) begin
                st_d.full = 1'b1;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt  = cnt_n[CW-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/ctd_emit.sv
module ctd_emit
    import ctd_pkg::*;
#(
    parameter int N = 127,
    parameter int R = 7,
    parameter logic [R-1:0] GEN = 7'h09
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_req,
    input  logic [N-1:0] load_word,
    input  logic [R-1:0] load_syn,
    input  logic         load_byp,
    output logic         load_ack,
    input  logic         out_ready,
    output logic         out_valid,
    output logic         out_data,
    output logic         out_fix,
    output logic         out_ok,
    output logic         out_sop,
    output logic         out_eop
);
    localparam int CW = $clog2(N + 1);
    localparam syn_t TRAP_FULL = syn_trap(N, syn_t'(GEN), R);
    localparam logic [R-1:0] TRAP = TRAP_FULL[R-1:0];

    typedef struct packed {
        logic [N-1:0]  word;
        logic [R-1:0]  syn;
        logic [CW-1:0] cnt;
        logic          busy;
        logic          byp;
        logic          ok;
    } emit_t;

    emit_t st_q, st_d;
    logic  trap_hit;
    logic  last_beat;
    syn_t  rot;

    assign trap_hit  = st_q.busy && !st_q.byp && (st_q.syn == TRAP);
    assign last_beat = st_q.busy && (st_q.cnt == CW'(N - 1));
    assign load_ack  = load_req && (!st_q.busy || (out_ready && last_beat));
    assign rot       = syn_mulx(syn_t'(st_q.syn), syn_t'(GEN), R);

    assign out_valid = st_q.busy;
    assign out_data  = st_q.word[N-1] ^ trap_hit;
    assign out_fix   = trap_hit;
    assign out_ok    = st_q.ok;
    assign out_sop   = st_q.busy && (st_q.cnt == '0);
    assign out_eop   = last_beat;

    always_comb begin
        st_d = st_q;
        if (st_q.busy && out_ready) begin
            st_d.word = {st_q.word[N-2:0], 1'b0};
            st_d.syn  = trap_hit ? '0 : rot[R-1:0];
            st_d.cnt  = st_q.cnt + CW'(1);
            if (last_beat) st_d.busy = 1'b0;
        end
        if (load_ack) begin
            st_d.word = load_word;
            st_d.syn  = load_syn;
            st_d.cnt  = '0;
            st_d.busy = 1'b1;
            st_d.byp  = load_byp;
            st_d.ok   = load_byp || (load_syn == '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/cyc_ham_trap_dec.sv
module cyc_ham_trap_dec
    import ctd_pkg::*;
#(
    parameter int N = 127,
    parameter int R = 7,
    parameter logic [R-1:0] GEN = 7'h09
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic in_ready,
    input  logic in_data,
    input  logic in_sop,
    input  logic in_bypass,
    output logic out_valid,
    input  logic out_ready,
    output logic out_data,
    output logic out_fix,
    output logic out_ok,
    output logic out_sop,
    output logic out_eop
);
    logic         c_full;
    logic [N-1:0] c_word;
    logic [R-1:0] c_syn;
    logic         c_byp;
    logic         e_ack;

    ctd_collect #(.N(N), .R(R), .GEN(GEN)) collect_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_valid  (in_valid),
        .bit_data   (in_data),
        .bit_sop    (in_sop),
        .bit_bypass (in_bypass),
        .take       (e_ack),
        .rdy        (in_ready),
        .full       (c_full),
        .word       (c_word),
        .syn        (c_syn),
        .byp        (c_byp)
    );

    ctd_emit #(.N(N), .R(R), .GEN(GEN)) emit_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_req  (c_full),
        .load_word (c_word),
        .load_syn  (c_syn),
        .load_byp  (c_byp),
        .load_ack  (e_ack),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_fix   (out_fix),
        .out_ok    (out_ok),
        .out_sop   (out_sop),
        .out_eop   (out_eop)
    );
endmodule

// File: rtl/ctd_checker.sv
module ctd_checker (
    input logic clk,
    input logic rst_n,
    input logic in_ready,
    input logic out_valid,
    input logic out_ready,
    input logic out_data,
    input logic out_fix,
    input logic out_ok,
    input logic out_sop,
    input logic out_eop
);
    logic seen_fix_q;
    logic fire;

    assign fire = out_valid && out_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    seen_fix_q <= 1'b0;
        else if (fire) seen_fix_q <= out_sop ? out_fix : (seen_fix_q || out_fix);
    end

    a_r8_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_fix)
                                   && $stable(out_ok) && $stable(out_sop) && $stable(out_eop));

    a_r11_ok_steady: assert property (@(posedge clk) disable iff (!rst_n)
        fire && !out_eop |=> out_valid && (out_ok == $past(out_ok)));

    a_r3_one_fix_per_word: assert property (@(posedge clk) disable iff (!rst_n)
        fire && out_fix && !out_sop |-> !seen_fix_q);

    a_r3_fix_means_bad_syndrome: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_fix |-> !out_ok);

    a_r9_idle_accepts: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

    a_r7_eop_then_sop: assert property (@(posedge clk) disable iff (!rst_n)
        fire && out_eop |=> !out_valid || out_sop);
endmodule

bind cyc_ham_trap_dec ctd_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_fix   (out_fix),
    .out_ok    (out_ok),
    .out_sop   (out_sop),
    .out_eop   (out_eop)
);

// File: tb/cyc_ham_trap_dec_tb_top.sv
module cyc_ham_trap_dec_tb_top;
    localparam int N = 127;
    localparam int R = 7;
    localparam int K = N - R;
    localparam logic [R-1:0] GEN = 7'h09;
    localparam logic [R:0] GPOLY = {1'b1, GEN};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_data = 1'b0, in_sop = 1'b0, in_bypass = 1'b0;
    logic out_ready = 1'b1;
    logic in_ready, out_valid, out_data, out_fix, out_ok, out_sop, out_eop;

    always #4 clk = ~clk;

    cyc_ham_trap_dec #(.N(N), .R(R), .GEN(GEN)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_sop(in_sop), .in_bypass(in_bypass),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_fix(out_fix), .out_ok(out_ok), .out_sop(out_sop), .out_eop(out_eop)
    );

    typedef struct {
        logic [4:0] v;   // {data, fix, ok, sop, eop}
        string      req;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails = 0;
    int   stalls = 0;
    bit   rdy_random = 1'b0;
    bit   done = 1'b0;

    task automatic check(input bit cond, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // systematic encoding by long division of m(x)*x^R by g(x)
    function automatic logic [N-1:0] encode(input logic [K-1:0] m);
        logic [N-1:0] w;
        logic [N-1:0] rem;
        w   = {m, {R{1'b0}}};
        rem = w;
        for (int d = N - 1; d >= R; d--)
            if (rem[d]) rem[d -: R+1] = rem[d -: R+1] ^ GPOLY;
        return w | rem;
    endfunction

    function automatic logic [K-1:0] rand_msg();
        return K'({$urandom, $urandom, $urandom, $urandom});
    endfunction

    task automatic drive_beat(input logic d, input logic sop, input logic byp, input bit gaps);
        bit acc;
        if (gaps && ($urandom % 4 == 0)) begin
            @(negedge clk);
            in_valid = 1'b0;
            @(posedge clk);
        end
        acc = 1'b0;
        do begin
            @(negedge clk);
            in_valid = 1'b1; in_data = d; in_sop = sop; in_bypass = byp;
            #2;
            acc = in_ready;
            if (!acc) stalls++;
            @(posedge clk);
        end while (!acc);
    endtask

    task automatic go_idle();
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_bypass = 1'b0;
    endtask

    // good: transmitted codeword, err: beat index flipped (-1 none)
    task automatic send_word(input logic [N-1:0] good, input int err, input bit byp_first,
                             input bit byp_rest, input bit gaps, input string req);
        logic [N-1:0] rx;
        exp_t e;
        rx = good;
        if (err >= 0) rx[N-1-err] = ~rx[N-1-err];
        for (int i = 0; i < N; i++) begin
            e.v[4] = byp_first ? rx[N-1-i] : good[N-1-i];
            e.v[3] = !byp_first && (i == err);
            e.v[2] = byp_first || (err < 0);
            e.v[1] = (i == 0);
            e.v[0] = (i == N - 1);
            e.req  = {req, " R7 R11", rdy_random ? " R8" : ""};
            q.push_back(e);
        end
        for (int i = 0; i < N; i++)
            drive_beat(rx[N-1-i], i == 0, (i == 0) ? byp_first : byp_rest, gaps);
    endtask

    // monitor and scoreboard
    initial begin
        forever begin
            @(negedge clk);
            out_ready = rdy_random ? ($urandom % 3 != 0) : 1'b1;
            #1;
            if (rst_n && out_valid && out_ready) begin
                if (q.size() == 0) begin
                    check(1'b0, "R6", "unexpected output beat",
                          {27'd0, out_data, out_fix, out_ok, out_sop, out_eop}, 32'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check({out_data, out_fix, out_ok, out_sop, out_eop} == e.v, e.req,
                          "beat {data,fix,ok,sop,eop}",
                          {27'd0, out_data, out_fix, out_ok, out_sop, out_eop}, {27'd0, e.v});
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(out_valid == 1'b0, "R10", "out_valid in reset", 32'(out_valid), 0);
        check(in_ready == 1'b1, "R10", "in_ready in reset", 32'(in_ready), 1);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(out_valid == 1'b0 && in_ready == 1'b1, "R10", "idle after reset",
              {30'd0, out_valid, in_ready}, 32'd1);

        // R9 latency, R1 clean word
        send_word(encode(rand_msg()), -1, 1'b0, 1'b0, 1'b0, "R1 R9");
        go_idle();
        #1;
        check(out_valid == 1'b0, "R9", "valid one edge after last bit", 32'(out_valid), 0);
        @(negedge clk);
        #1;
        check(out_valid && out_sop, "R9", "valid two edges after last bit",
              {30'd0, out_valid, out_sop}, 32'd3);
        while (q.size() != 0) @(posedge clk);

        // R9 back-to-back streaming
        stalls = 0;
        for (int w = 0; w < 3; w++)
            send_word(encode(rand_msg()), w, 1'b0, 1'b0, 1'b0, "R2 R9");
        go_idle();
        check(stalls == 0, "R9", "input stalls while streaming", 32'(stalls), 0);

        // R2, R3: error at every beat position
        rdy_random = 1'b1;
        for (int e = 0; e < N; e++)
            send_word(encode(rand_msg()), e, 1'b0, 1'b0, (e % 3 == 0), "R2 R3");

        // R1 clean words, including all zero and all ones message
        send_word(encode('0), -1, 1'b0, 1'b0, 1'b1, "R1");
        send_word(encode('1), -1, 1'b0, 1'b0, 1'b1, "R1");
        for (int w = 0; w < 6; w++)
            send_word(encode(rand_msg()), -1, 1'b0, 1'b0, 1'b1, "R1");

        // R4 bypassed words, with and without errors
        for (int w = 0; w < 4; w++)
            send_word(encode(rand_msg()), 17 * w + 3, 1'b1, 1'b0, 1'b1, "R4");
        send_word(encode(rand_msg()), -1, 1'b1, 1'b1, 1'b0, "R4");

        // R5 bypass asserted only on later beats has no effect
        for (int w = 0; w < 3; w++)
            send_word(encode(rand_msg()), 40 * w + 1, 1'b0, 1'b1, 1'b1, "R5");

        // R6 partial word abandoned by a new start marker
        for (int i = 0; i < 9; i++) drive_beat(1'b1, i == 0, 1'b0, 1'b0);
        send_word(encode(rand_msg()), 60, 1'b0, 1'b0, 1'b0, "R6 R2");
        go_idle();

        rdy_random = 1'b0;
        repeat (4 * N) @(posedge clk);
        @(negedge clk);
        #2;
        check(q.size() == 0, "R6", "words pending at end", 32'(q.size()), 0);
        check(out_valid == 1'b0, "R6", "extra output at end", 32'(out_valid), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule